// File: doc/BRIEF.md
# Iterative Shift-Add Multiply and Divide Unit

This block is an arithmetic helper that sits behind a register interface. It computes an unsigned 8 by 8 product or an unsigned 16 by 8 quotient and remainder. It works one bit per clock edge. A one-cycle start strobe latches the operands. Each following edge runs one shift-and-add step for a multiply, or one shift-and-subtract step for a divide. Multiply and divide use the same two result registers and the same internal shift register. Each operation has its own step down-counter. Software may read the results at any time. While an operation is running it sees the partial values.

A small state machine tracks which operation is running. `ST_IDLE` moves to `ST_MUL` on a multiply strobe and to `ST_DIV` on a divide strobe. A divide strobe always wins, including over a multiply strobe on the same edge. `ST_MUL` and `ST_DIV` return to `ST_IDLE` on the edge that consumes their last step. Either strobe in any state restarts the machine, which abandons any operation in flight.

Top module: `muldiv_unit`

## Requirements
- R1: After reset, `busy` is 0 and `res_quo` and `res_rem` are both 0.
- R2: On the edge after a multiply start, `busy` is 1, `res_rem` is 0, and `res_quo` holds the multiplier zero-extended to 16 bits.
- R3: A multiply ends with `res_rem` equal to multiplicand times multiplier, as a 16-bit value, and `res_quo` equal to 0.
- R4: `busy` stays high for exactly 8 cycles after a multiply start edge and for exactly 16 cycles after a divide start edge.
- R5: On the edge after a divide start, `busy` is 1, `res_quo` is 0, and `res_rem` holds the dividend.
- R6: A divide with a nonzero divisor ends with `res_quo` equal to the floor of the dividend divided by the divisor, and `res_rem` equal to the remainder.
- R7: A divide by zero ends with `res_quo` equal to 16'hFFFF and `res_rem` equal to the dividend.
- R8: Partial results are visible. After k multiply steps, `res_quo` equals the multiplier shifted right by k. During a divide, each step shifts `res_quo` left by one.
- R9: A start strobe while `busy` is high abandons the running operation. The new operation completes with its own correct result.
- R10: If both start strobes are high on the same edge, the divide is performed and the multiply strobe is ignored.
- R11: While idle with no start strobe, `res_quo` and `res_rem` hold their values whatever the operand inputs do.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| mul_go | input | 1 | Multiply start strobe |
| mul_a | input | 8 | Multiplicand |
| mul_b | input | 8 | Multiplier |
| div_go | input | 1 | Divide start strobe (wins over `mul_go`) |
| div_n | input | 16 | Dividend |
| div_d | input | 8 | Divisor |
| busy | output | 1 | An operation is in progress |
| res_quo | output | 16 | Quotient register; multiplier shift register during a multiply |
| res_rem | output | 16 | Remainder register; product accumulator during a multiply |

## Verification
The assertions check the following on every cycle:
- the register loads on a start edge;
- the one-bit shift of `res_quo` on each multiply and divide step;
- the agreement of `busy` with the state;
- the exact busy length, measured with a step counter;
- that the results hold while idle.

Only the bench scenarios can show the final arithmetic: the product, the quotient and remainder, and the all-ones quotient on divide by zero. The same applies to restart mid-operation, the same-edge strobe priority, and holding against changing operand inputs.

// File: rtl/muldiv_pkg.sv
package muldiv_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_MUL  = 2'd1,
        ST_DIV  = 2'd2
    } md_state_t;
endpackage

// File: rtl/muldiv_mul_step.sv
module muldiv_mul_step #(
    parameter int NUMW = 16,
    parameter int SHW  = 24
) (
    input  logic            en,
    input  logic [NUMW-1:0] quo_i,
    input  logic [NUMW-1:0] rem_i,
    input  logic [SHW-1:0]  shf_i,
    output logic [NUMW-1:0] quo_o,
    output logic [NUMW-1:0] rem_o,
    output logic [SHW-1:0]  shf_o
);
    always_comb begin
        quo_o = quo_i;
        rem_o = rem_i;
        shf_o = shf_i;
        if (en) begin
            if (quo_i[0]) begin
                rem_o = rem_i + shf_i[NUMW-1:0];
            end
            quo_o = quo_i >> 1;
            shf_o = shf_i << 1;
        end
    end
endmodule

// File: rtl/muldiv_div_step.sv
module muldiv_div_step #(
    parameter int NUMW = 16,
    parameter int SHW  = 24
) (
    input  logic            en,
    input  logic [NUMW-1:0] quo_i,
    input  logic [NUMW-1:0] rem_i,
    input  logic [SHW-1:0]  shf_i,
    output logic [NUMW-1:0] quo_o,
    output logic [NUMW-1:0] rem_o,
    output logic [SHW-1:0]  shf_o
);
    localparam int PADW = SHW - NUMW;

    logic [SHW-1:0] shf_n;
    logic [SHW-1:0] rem_wide;

    always_comb begin
        quo_o    = quo_i;
        rem_o    = rem_i;
        shf_n    = shf_i >> 1;
        rem_wide = {{PADW{1'b0}}, rem_i};
        shf_o    = shf_i;
        if (en) begin
            quo_o = quo_i << 1;
            shf_o = shf_n;
            if (rem_wide >= shf_n) begin
                rem_o    = rem_i - shf_n[NUMW-1:0];
                quo_o[0] = 1'b1;
            end
        end
    end
endmodule

// File: rtl/muldiv_ctrl.sv
module muldiv_ctrl
    import muldiv_pkg::*;
#(
    parameter int MUL_STEPS = 8,
    parameter int DIV_STEPS = 16,
    parameter int CW        = 5
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      mul_go,
    input  logic      div_go,
    output logic      load_mul,
    output logic      load_div,
    output logic      mul_en,
    output logic      div_en,
    output logic      busy,
    output md_state_t state_q
);
    md_state_t     state_d;
    logic [CW-1:0] mul_cnt;
    logic [CW-1:0] div_cnt;

    always_comb begin
        load_div = div_go;
        load_mul = mul_go && !div_go;
        mul_en   = (mul_cnt != '0) && !load_div && !load_mul;
        div_en   = (div_cnt != '0) && !load_div && !load_mul;
        busy     = (mul_cnt != '0) || (div_cnt != '0);
    end

    always_comb begin
        state_d = state_q;
        if (load_div) begin
            state_d = ST_DIV;
        end else if (load_mul) begin
            state_d = ST_MUL;
        end else begin
            unique case (state_q)
                ST_IDLE: state_d = ST_IDLE;
                ST_MUL:  if (mul_cnt == CW'(1)) state_d = ST_IDLE;
                ST_DIV:  if (div_cnt == CW'(1)) state_d = ST_IDLE;
                default: state_d = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mul_cnt <= '0;
            div_cnt <= '0;
        end else if (load_div) begin
            mul_cnt <= '0;
            div_cnt <= CW'(DIV_STEPS);
        end else if (load_mul) begin
            mul_cnt <= CW'(MUL_STEPS);
            div_cnt <= '0;
        end else begin
            if (mul_cnt != '0) mul_cnt <= mul_cnt - CW'(1);
            if (div_cnt != '0) div_cnt <= div_cnt - CW'(1);
        end
    end
endmodule

// File: rtl/muldiv_unit.sv
module muldiv_unit
    import muldiv_pkg::*;
#(
    parameter int OPW = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 mul_go,
    input  logic [OPW-1:0]       mul_a,
    input  logic [OPW-1:0]       mul_b,
    input  logic                 div_go,
    input  logic [2*OPW-1:0]     div_n,
    input  logic [OPW-1:0]       div_d,
    output logic                 busy,
    output logic [2*OPW-1:0]     res_quo,
    output logic [2*OPW-1:0]     res_rem
);
    localparam int NUMW = 2 * OPW;
    localparam int SHW  = NUMW + OPW;
    localparam int CW   = $clog2(NUMW + 1);

    logic            load_mul, load_div, mul_en, div_en;
    md_state_t       state_q;
    logic [NUMW-1:0] quo_q, rem_q;
    logic [SHW-1:0]  shf_q;
    logic [NUMW-1:0] quo_m, rem_m, quo_s, rem_s;
    logic [SHW-1:0]  shf_m, shf_s;

    muldiv_ctrl #(.MUL_STEPS(OPW), .DIV_STEPS(NUMW), .CW(CW)) ctrl_i (
        .clk(clk), .rst_n(rst_n), .mul_go(mul_go), .div_go(div_go),
        .load_mul(load_mul), .load_div(load_div),
        .mul_en(mul_en), .div_en(div_en), .busy(busy), .state_q(state_q)
    );

    // multiply step first, divide step second, within one edge
    muldiv_mul_step #(.NUMW(NUMW), .SHW(SHW)) mstep_i (
        .en(mul_en), .quo_i(quo_q), .rem_i(rem_q), .shf_i(shf_q),
        .quo_o(quo_m), .rem_o(rem_m), .shf_o(shf_m)
    );

    muldiv_div_step #(.NUMW(NUMW), .SHW(SHW)) dstep_i (
        .en(div_en), .quo_i(quo_m), .rem_i(rem_m), .shf_i(shf_m),
        .quo_o(quo_s), .rem_o(rem_s), .shf_o(shf_s)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            quo_q <= '0;
            rem_q <= '0;
            shf_q <= '0;
        end else if (load_div) begin
            quo_q <= '0;
            rem_q <= div_n;
            shf_q <= {div_d, {NUMW{1'b0}}};
        end else if (load_mul) begin
            quo_q <= {{OPW{1'b0}}, mul_b};
            rem_q <= '0;
            shf_q <= {{NUMW{1'b0}}, mul_a};
        end else begin
            quo_q <= quo_s;
            rem_q <= rem_s;
            shf_q <= shf_s;
        end
    end

    always_comb begin
        res_quo = quo_q;
        res_rem = rem_q;
    end
endmodule

// File: rtl/muldiv_unit_chk.sv
module muldiv_unit_chk
    import muldiv_pkg::*;
#(
    parameter int OPW = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               mul_go,
    input logic               div_go,
    input logic [OPW-1:0]     mul_b,
    input logic [2*OPW-1:0]   div_n,
    input logic               busy,
    input logic [2*OPW-1:0]   res_quo,
    input logic [2*OPW-1:0]   res_rem,
    input md_state_t          state_q
);
    localparam int NUMW = 2 * OPW;
    localparam int CW   = $clog2(NUMW + 2);

    logic [CW-1:0] run_cnt;
    logic          last_div;
    logic          any_go;

    assign any_go = mul_go || div_go;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_cnt  <= '0;
            last_div <= 1'b0;
        end else if (any_go) begin
            run_cnt  <= '0;
            last_div <= div_go;
        end else if (busy) begin
            run_cnt  <= run_cnt + CW'(1);
        end
    end

    AST_MUL_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (mul_go && !div_go) |=> (busy && res_rem == '0 && res_quo == {{OPW{1'b0}}, $past(mul_b)})); // R2

    AST_DIV_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        div_go |=> (busy && res_quo == '0 && res_rem == $past(div_n) && state_q == ST_DIV)); // R5

    AST_BUSY_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(busy) && !$past(any_go)) |-> (run_cnt == (last_div ? CW'(NUMW) : CW'(OPW)))); // R4

    AST_BUSY_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        busy == (state_q != ST_IDLE)); // R4

    AST_MUL_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_MUL && !any_go) |=> (res_quo == ($past(res_quo) >> 1))); // R8

    AST_DIV_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DIV && !any_go) |=> (res_quo[NUMW-1:1] == $past(res_quo[NUMW-2:0]))); // R8

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !any_go) |=> ($stable(res_quo) && $stable(res_rem))); // R11
endmodule

bind muldiv_unit muldiv_unit_chk #(.OPW(OPW)) chk_i (
    .clk(clk), .rst_n(rst_n), .mul_go(mul_go), .div_go(div_go),
    .mul_b(mul_b), .div_n(div_n), .busy(busy),
    .res_quo(res_quo), .res_rem(res_rem), .state_q(state_q)
);

// File: tb/muldiv_unit_tb_top.sv
module muldiv_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mul_go = 1'b0;
    logic [7:0]  mul_a = '0;
    logic [7:0]  mul_b = '0;
    logic        div_go = 1'b0;
    logic [15:0] div_n = '0;
    logic [7:0]  div_d = '0;
    logic        busy;
    logic [15:0] res_quo, res_rem;

    typedef struct {
        logic [15:0] quo;
        logic [15:0] rem;
        string       tag;
    } exp_t;

    exp_t exp_q[$];
    int   total = 0;
    int   bad   = 0;
    logic busy_prev = 1'b0;

    always #2 clk = ~clk;

    muldiv_unit dut_i (
        .clk(clk), .rst_n(rst_n), .mul_go(mul_go), .mul_a(mul_a), .mul_b(mul_b),
        .div_go(div_go), .div_n(div_n), .div_d(div_d),
        .busy(busy), .res_quo(res_quo), .res_rem(res_rem)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] expv);
        total++;
        if (act !== expv) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    // monitor: compares final results when busy falls
    always @(negedge clk) begin
        if (rst_n && busy_prev && !busy) begin
            if (exp_q.size() == 0) begin
                check("R3/R6 unexpected completion", 1, 0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                check({e.tag, " quo"}, {16'h0, res_quo}, {16'h0, e.quo});
                check({e.tag, " rem"}, {16'h0, res_rem}, {16'h0, e.rem});
            end
        end
        busy_prev = busy;
    end

    task automatic push_mul(input logic [7:0] a, input logic [7:0] b, input string tag);
        exp_t e;
        e.quo = 16'h0;
        e.rem = 16'(a) * 16'(b);
        e.tag = tag;
        exp_q.push_back(e);
    endtask

    task automatic push_div(input logic [15:0] n, input logic [7:0] d, input string tag);
        exp_t e;
        if (d == 0) begin
            e.quo = 16'hFFFF;
            e.rem = n;
        end else begin
            e.quo = n / 16'(d);
            e.rem = n % 16'(d);
        end
        e.tag = tag;
        exp_q.push_back(e);
    endtask

    task automatic wait_idle(output int cnt);
        cnt = 0;
        while (busy) begin
            cnt++;
            @(negedge clk);
        end
    endtask

    task automatic run_mul(input logic [7:0] a, input logic [7:0] b, input string tag);
        int cnt;
        push_mul(a, b, tag);
        @(negedge clk);
        mul_go = 1'b1; mul_a = a; mul_b = b;
        @(negedge clk);
        mul_go = 1'b0;
        check("R2 busy", {31'h0, busy}, 1);
        check("R2 quo load", {16'h0, res_quo}, {24'h0, b});
        check("R2 rem clear", {16'h0, res_rem}, 0);
        @(negedge clk);
        check("R8 partial quo", {16'h0, res_quo}, {25'h0, b[7:1]});
        check("R8 partial rem", {16'h0, res_rem}, b[0] ? {24'h0, a} : 32'h0);
        wait_idle(cnt);
        check("R4 mul busy cycles", cnt + 1, 8);
    endtask

    task automatic run_div(input logic [15:0] n, input logic [7:0] d, input string tag);
        int cnt;
        push_div(n, d, tag);
        @(negedge clk);
        div_go = 1'b1; div_n = n; div_d = d;
        @(negedge clk);
        div_go = 1'b0;
        check("R5 quo clear", {16'h0, res_quo}, 0);
        check("R5 rem load", {16'h0, res_rem}, {16'h0, n});
        wait_idle(cnt);
        check("R4 div busy cycles", cnt, 16);
    endtask

    initial begin
        int cnt;
        repeat (3) @(negedge clk);
        check("R1 busy", {31'h0, busy}, 0);
        check("R1 quo", {16'h0, res_quo}, 0);
        check("R1 rem", {16'h0, res_rem}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        run_mul(8'd13, 8'd11, "R3 mul 13x11");
        run_mul(8'hFF, 8'hFF, "R3 mul max");
        run_mul(8'h00, 8'hA5, "R3 mul zero");
        run_div(16'd1000, 8'd7, "R6 div 1000/7");
        run_div(16'hFFFF, 8'd1, "R6 div by one");
        run_div(16'd5, 8'd200, "R6 div small");
        run_div(16'h1234, 8'd0, "R7 div by zero");

        // R9: restart a multiply by a divide mid-flight
        push_div(16'd999, 8'd10, "R9 restart");
        @(negedge clk);
        mul_go = 1'b1; mul_a = 8'd77; mul_b = 8'd99;
        @(negedge clk);
        mul_go = 1'b0;
        repeat (3) @(negedge clk);
        div_go = 1'b1; div_n = 16'd999; div_d = 8'd10;
        @(negedge clk);
        div_go = 1'b0;
        wait_idle(cnt);

        // R10: both strobes on one edge, divide wins
        push_div(16'd300, 8'd9, "R10 both strobes");
        @(negedge clk);
        mul_go = 1'b1; mul_a = 8'd5; mul_b = 8'd6;
        div_go = 1'b1; div_n = 16'd300; div_d = 8'd9;
        @(negedge clk);
        mul_go = 1'b0; div_go = 1'b0;
        wait_idle(cnt);
        check("R10 div length", cnt, 16);

        // R11: results hold while idle with operand noise
        repeat (2) @(negedge clk);
        mul_a = 8'h3C; mul_b = 8'hC3; div_n = 16'hBEEF; div_d = 8'h11;
        repeat (4) @(negedge clk);
        check("R11 hold quo", {16'h0, res_quo}, 16'd33);
        check("R11 hold rem", {16'h0, res_rem}, 16'd3);
        check("R3/R6 queue drained", exp_q.size(), 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule